// File: doc/BRIEF.md
# Rotate-Left Execution Unit with Carry and Overflow Flags

This unit performs a left rotation for an integer datapath in which bits leaving the top of the operand come back in at the bottom. The operand width is chosen per operation as 8, 16 or 32 bits. An operation class input picks where the rotate amount comes from: the constant one, an immediate byte, or a byte from a count register.

A mode input chooses how much of that byte counts. In masked mode only its low five bits are used. In legacy mode all eight bits are used. Any amount of at least the operand width wraps modulo the width. When the rotation really happens, the carry flag takes the last bit carried around, and the overflow flag is driven as the result's top bit XOR the new carry. A write-enable is raised for each of those two flags. All other flags in the flag word pass through untouched. An amount that is zero after masking leaves the data, the flags and both write-enables idle.

The inputs are captured on a valid strobe. The result, the flags and an output valid appear from those registers on the following clock. The reset is synchronous and active high.

Top module: `rotl_exec_unit`

## Requirements
- R1: The result is the operand rotated left within the selected width: size 0 is 8 bits, size 1 is 16 bits, and sizes 2 and 3 are 32 bits. Operand bits above the width are ignored, and result bits above the width are 0.
- R2: The count source is chosen by `in_src`: 0 gives the constant 1, 1 gives `in_imm`, and 2 or 3 give `in_creg`.
- R3: When `legacy_mode` is 0, only the low 5 bits of the selected count are used. When it is 1, all 8 bits are used.
- R4: A nonzero effective count is applied modulo the width. A nonzero multiple of the width returns the operand unchanged while still writing the carry, which then equals result bit 0.
- R5: When the effective count is nonzero, `cf_we` is 1 and the carry flag (flag bit 0) equals result bit 0.
- R6: When the effective count is nonzero, `of_we` is 1 and the overflow flag (flag bit 8) equals the result's top bit XOR the new carry. For a count of one, this is 1 exactly when the operand's sign bit changed.
- R7: When the effective count is zero, the result equals the operand within the width, both write-enables are 0, and `out_flags` equals `in_flags`.
- R8: Flag bits 1 to 7 of `out_flags` always equal those of the captured `in_flags`.
- R9: Inputs are captured only on a clock edge with `in_valid` high, and `out_valid` follows `in_valid` by one clock. Reset clears `out_valid` and every captured register to 0, and outputs hold while `in_valid` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Capture strobe for all operation inputs |
| in_size | input | 2 | Operand width select |
| in_src | input | 2 | Count source select |
| in_imm | input | 8 | Immediate count byte |
| in_creg | input | 8 | Count register byte |
| legacy_mode | input | 1 | 1 uses all 8 count bits, 0 uses the low 5 |
| in_data | input | 32 | Operand |
| in_flags | input | 9 | Incoming flag word, carry at bit 0 and overflow at bit 8 |
| out_valid | output | 1 | Result valid, one clock after the strobe |
| out_data | output | 32 | Rotated result, zero above the width |
| out_flags | output | 9 | Outgoing flag word |
| cf_we | output | 1 | Carry flag write-enable |
| of_we | output | 1 | Overflow flag write-enable |

## Verification
Each count source is driven with the other two sources holding values that would give a different result, so a wrong source select shows up in the output. Rotates of 1, 4, 8 and 31 positions on each width test the shifter stages and the wrap within the chosen width. Counts equal to, above and at multiples of the width separate modulo wrapping from masking. The pair of count 0x20 in both modes tells the zero-count idle case apart from a full-width rotate that still writes the carry. Operands with garbage above the width, and flag words with every pass-through bit set and cleared, show whether unused bits leak into the result or the flags.

// File: rtl/rotl_pkg.sv
package rotl_pkg;

   typedef enum logic [1:0] {
      SZ_BYTE  = 2'd0,
      SZ_WORD  = 2'd1,
      SZ_DWORD = 2'd2,
      SZ_ALT   = 2'd3
   } rotl_size_e;

   typedef enum logic [1:0] {
      SRC_ONE     = 2'd0,
      SRC_IMM     = 2'd1,
      SRC_REG     = 2'd2,
      SRC_REG_ALT = 2'd3
   } rotl_src_e;

   localparam int FLAG_W  = 9;
   localparam int FLAG_CF = 0;
   localparam int FLAG_OF = 8;

endpackage

// File: rtl/rotl_count_sel.sv
module rotl_count_sel
   import rotl_pkg::*;
#(
   parameter int CNT_W  = 8,
   parameter int MASK_W = 5
) (
   input  rotl_src_e          src_i,
   input  logic [CNT_W-1:0]   imm_i,
   input  logic [CNT_W-1:0]   creg_i,
   input  logic               legacy_i,
   output logic [CNT_W-1:0]   eff_o,
   output logic               zero_o
);

   localparam logic [CNT_W-1:0] KEEP_MASK = CNT_W'((1 << MASK_W) - 1);

   if (MASK_W > CNT_W || MASK_W < 1) begin : g_bad_mask
      $error("rotl_count_sel: MASK_W must lie in 1..CNT_W");
   end

   logic [CNT_W-1:0] raw_cnt;

   always_comb begin
      unique case (src_i)
         SRC_ONE: raw_cnt = CNT_W'(1);
         SRC_IMM: raw_cnt = imm_i;
         default: raw_cnt = creg_i;
      endcase
   end

   assign eff_o  = legacy_i ? raw_cnt : (raw_cnt & KEEP_MASK);
   assign zero_o = (eff_o == '0);

endmodule

// File: rtl/rotl_barrel.sv
module rotl_barrel #(
   parameter int DATA_W    = 32,
   parameter int MIN_W     = 8,
   parameter int NUM_SIZES = 3,
   localparam int SH_W     = $clog2(DATA_W),
   localparam int SEL_W    = (NUM_SIZES > 1) ? $clog2(NUM_SIZES) + 1 : 1
) (
   input  logic [DATA_W-1:0] data_i,
   input  logic [1:0]        size_i,
   input  logic [SH_W-1:0]   cnt_i,
   output logic [DATA_W-1:0] result_o
);

   logic [DATA_W-1:0] per_size [NUM_SIZES];

   for (genvar s = 0; s < NUM_SIZES; s++) begin : g_size
      localparam int W  = MIN_W << s;
      localparam int SW = $clog2(W);
      logic [W-1:0] stg [SW+1];

      assign stg[0] = data_i[W-1:0];
      for (genvar k = 0; k < SW; k++) begin : g_stage
         localparam int SH = 1 << k;
         assign stg[k+1] = cnt_i[k] ? ((stg[k] << SH) | (stg[k] >> (W - SH)))
                                    : stg[k];
      end
      assign per_size[s] = DATA_W'(stg[SW]);
   end

   logic [SEL_W-1:0] sel;
   always_comb begin
      if (SEL_W'(size_i) >= SEL_W'(NUM_SIZES)) sel = SEL_W'(NUM_SIZES - 1);
      else                                      sel = SEL_W'(size_i);
   end

   assign result_o = per_size[sel];

endmodule

// File: rtl/rotl_flag_gen.sv
module rotl_flag_gen
   import rotl_pkg::*;
#(
   parameter int DATA_W    = 32,
   parameter int MIN_W     = 8,
   parameter int NUM_SIZES = 3,
   localparam int SEL_W    = (NUM_SIZES > 1) ? $clog2(NUM_SIZES) + 1 : 1
) (
   input  logic [DATA_W-1:0] result_i,
   input  logic [1:0]        size_i,
   input  logic              zero_i,
   input  logic [FLAG_W-1:0] flags_i,
   output logic [FLAG_W-1:0] flags_o,
   output logic              cf_we_o,
   output logic              of_we_o
);

   logic [NUM_SIZES-1:0] msb_vec;
   for (genvar s = 0; s < NUM_SIZES; s++) begin : g_msb
      assign msb_vec[s] = result_i[(MIN_W << s) - 1];
   end

   logic [SEL_W-1:0] sel;
   always_comb begin
      if (SEL_W'(size_i) >= SEL_W'(NUM_SIZES)) sel = SEL_W'(NUM_SIZES - 1);
      else                                      sel = SEL_W'(size_i);
   end

   logic top_bit, new_cf;
   assign top_bit = msb_vec[sel];
   assign new_cf  = result_i[0];

   always_comb begin
      flags_o = flags_i;
      if (!zero_i) begin
         flags_o[FLAG_CF] = new_cf;
         flags_o[FLAG_OF] = top_bit ^ new_cf;
      end
   end

   assign cf_we_o = !zero_i;
   assign of_we_o = !zero_i;

endmodule

// File: rtl/rotl_exec_unit.sv
module rotl_exec_unit
   import rotl_pkg::*;
#(
   parameter int DATA_W    = 32,
   parameter int MIN_W     = 8,
   parameter int NUM_SIZES = 3,
   parameter int CNT_W     = 8,
   parameter int MASK_W    = 5
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              in_valid,
   input  logic [1:0]        in_size,
   input  logic [1:0]        in_src,
   input  logic [CNT_W-1:0]  in_imm,
   input  logic [CNT_W-1:0]  in_creg,
   input  logic              legacy_mode,
   input  logic [DATA_W-1:0] in_data,
   input  logic [8:0]        in_flags,
   output logic              out_valid,
   output logic [DATA_W-1:0] out_data,
   output logic [8:0]        out_flags,
   output logic              cf_we,
   output logic              of_we
);

   localparam int SH_W  = $clog2(DATA_W);
   localparam int SEL_W = (NUM_SIZES > 1) ? $clog2(NUM_SIZES) + 1 : 1;

   if (DATA_W != (MIN_W << (NUM_SIZES - 1))) begin : g_bad_width
      $error("rotl_exec_unit: DATA_W must equal MIN_W << (NUM_SIZES-1)");
   end
   if ((MIN_W & (MIN_W - 1)) != 0 || MIN_W < 2) begin : g_bad_min
      $error("rotl_exec_unit: MIN_W must be a power of two");
   end
   if (CNT_W < SH_W) begin : g_bad_cnt
      $error("rotl_exec_unit: CNT_W too narrow for DATA_W");
   end
   if (FLAG_W != 9) begin : g_bad_flags
      $error("rotl_exec_unit: flag word width mismatch");
   end

   // capture registers
   logic              vld_q;
   logic [1:0]        size_q;
   rotl_src_e         src_q;
   logic [CNT_W-1:0]  imm_q, creg_q;
   logic              leg_q;
   logic [DATA_W-1:0] data_q;
   logic [8:0]        flags_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         vld_q   <= 1'b0;
         size_q  <= '0;
         src_q   <= SRC_ONE;
         imm_q   <= '0;
         creg_q  <= '0;
         leg_q   <= 1'b0;
         data_q  <= '0;
         flags_q <= '0;
      end else begin
         vld_q <= in_valid;
         if (in_valid) begin
            size_q  <= in_size;
            src_q   <= rotl_src_e'(in_src);
            imm_q   <= in_imm;
            creg_q  <= in_creg;
            leg_q   <= legacy_mode;
            data_q  <= in_data;
            flags_q <= in_flags;
         end
      end
   end

   logic [CNT_W-1:0] eff_cnt;
   logic             cnt_zero;

   rotl_count_sel #(.CNT_W(CNT_W), .MASK_W(MASK_W)) u_cnt (
      .src_i    (src_q),
      .imm_i    (imm_q),
      .creg_i   (creg_q),
      .legacy_i (leg_q),
      .eff_o    (eff_cnt),
      .zero_o   (cnt_zero)
   );

   rotl_barrel #(.DATA_W(DATA_W), .MIN_W(MIN_W), .NUM_SIZES(NUM_SIZES)) u_rot (
      .data_i   (data_q),
      .size_i   (size_q),
      .cnt_i    (eff_cnt[SH_W-1:0]),
      .result_o (out_data)
   );

   rotl_flag_gen #(.DATA_W(DATA_W), .MIN_W(MIN_W), .NUM_SIZES(NUM_SIZES)) u_flg (
      .result_i (out_data),
      .size_i   (size_q),
      .zero_i   (cnt_zero),
      .flags_i  (flags_q),
      .flags_o  (out_flags),
      .cf_we_o  (cf_we),
      .of_we_o  (of_we)
   );

   assign out_valid = vld_q;

   // checking helpers: width mask and top bit of captured operand and result
   logic [DATA_W-1:0]    chk_mask_v [NUM_SIZES];
   logic [NUM_SIZES-1:0] chk_in_msb, chk_out_msb;
   for (genvar s = 0; s < NUM_SIZES; s++) begin : g_chk
      assign chk_mask_v[s]  = DATA_W'({(MIN_W << s){1'b1}});
      assign chk_in_msb[s]  = data_q[(MIN_W << s) - 1];
      assign chk_out_msb[s] = out_data[(MIN_W << s) - 1];
   end
   logic [SEL_W-1:0] chk_sel;
   always_comb begin
      if (SEL_W'(size_q) >= SEL_W'(NUM_SIZES)) chk_sel = SEL_W'(NUM_SIZES - 1);
      else                                      chk_sel = SEL_W'(size_q);
   end
   logic [DATA_W-1:0] chk_mask;
   assign chk_mask = chk_mask_v[chk_sel];

   AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
      in_valid |=> out_valid);                                            // R9
   AST_VALID_DROPS: assert property (@(posedge clk) disable iff (rst)
      !in_valid |=> !out_valid);                                          // R9
   AST_BITS_KEPT: assert property (@(posedge clk) disable iff (rst)
      out_valid |-> ($countones(out_data) == $countones(data_q & chk_mask))); // R1
   AST_ABOVE_WIDTH_ZERO: assert property (@(posedge clk) disable iff (rst)
      out_valid |-> ((out_data & ~chk_mask) == '0));                      // R1
   AST_CARRY_LSB: assert property (@(posedge clk) disable iff (rst)
      (out_valid && cf_we) |-> (out_flags[FLAG_CF] == out_data[0]));      // R5
   AST_SIGN_CHANGE: assert property (@(posedge clk) disable iff (rst)
      (out_valid && src_q == SRC_ONE) |->
      (of_we && out_flags[FLAG_OF] == (chk_out_msb[chk_sel] ^ chk_in_msb[chk_sel]))); // R6
   AST_PASS_OTHERS: assert property (@(posedge clk) disable iff (rst)
      out_valid |-> (out_flags[7:1] == flags_q[7:1]));                    // R8
   AST_ZERO_IDLE: assert property (@(posedge clk) disable iff (rst)
      (out_valid && !cf_we) |->
      (!of_we && out_data == (data_q & chk_mask) && out_flags == flags_q)); // R7
   AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
      (!in_valid && !$past(rst)) |=> $stable(out_data));                  // R9

endmodule

// File: tb/rotl_exec_unit_tb_top.sv
module rotl_exec_unit_tb_top;

   logic        clk = 1'b0;
   logic        rst;
   logic        in_valid;
   logic [1:0]  in_size, in_src;
   logic [7:0]  in_imm, in_creg;
   logic        legacy_mode;
   logic [31:0] in_data;
   logic [8:0]  in_flags;
   logic        out_valid;
   logic [31:0] out_data;
   logic [8:0]  out_flags;
   logic        cf_we, of_we;

   always #2 clk = ~clk;   // 250 MHz

   rotl_exec_unit dut_i (
      .clk(clk), .rst(rst), .in_valid(in_valid), .in_size(in_size),
      .in_src(in_src), .in_imm(in_imm), .in_creg(in_creg),
      .legacy_mode(legacy_mode), .in_data(in_data), .in_flags(in_flags),
      .out_valid(out_valid), .out_data(out_data), .out_flags(out_flags),
      .cf_we(cf_we), .of_we(of_we)
   );

   typedef struct packed {
      logic [1:0]  size;
      logic [1:0]  src;
      logic        leg;
      logic [7:0]  imm;
      logic [7:0]  creg;
      logic [31:0] data;
      logic [8:0]  flags;
      logic [31:0] exp_data;
      logic        exp_we;
   } vec_t;

   localparam int NV = 12;
   localparam vec_t VECS [NV] = '{
      '{2'd0, 2'd0, 1'b0, 8'h00, 8'h07, 32'h0000_0081, 9'h0AA, 32'h0000_0003, 1'b1},
      '{2'd1, 2'd1, 1'b0, 8'h04, 8'h00, 32'h0000_1234, 9'h155, 32'h0000_2341, 1'b1},
      '{2'd2, 2'd2, 1'b0, 8'h00, 8'h08, 32'h1234_5678, 9'h000, 32'h3456_7812, 1'b1},
      '{2'd0, 2'd1, 1'b0, 8'h08, 8'h03, 32'h0000_00A5, 9'h1FF, 32'h0000_00A5, 1'b1},
      '{2'd0, 2'd2, 1'b0, 8'h01, 8'h20, 32'h0000_005A, 9'h101, 32'h0000_005A, 1'b0},
      '{2'd0, 2'd2, 1'b1, 8'h01, 8'h20, 32'h0000_005A, 9'h101, 32'h0000_005A, 1'b1},
      '{2'd1, 2'd1, 1'b0, 8'h11, 8'h00, 32'h0000_8001, 9'h000, 32'h0000_0003, 1'b1},
      '{2'd2, 2'd0, 1'b0, 8'h05, 8'h05, 32'h4000_0000, 9'h0FE, 32'h8000_0000, 1'b1},
      '{2'd0, 2'd0, 1'b0, 8'h00, 8'h00, 32'hFFFF_FF01, 9'h100, 32'h0000_0002, 1'b1},
      '{2'd2, 2'd3, 1'b1, 8'h00, 8'hE3, 32'h0000_0001, 9'h1FE, 32'h0000_0008, 1'b1},
      '{2'd1, 2'd2, 1'b1, 8'h00, 8'h10, 32'hFFFF_BEEF, 9'h001, 32'h0000_BEEF, 1'b1},
      '{2'd2, 2'd1, 1'b0, 8'h3F, 8'h00, 32'h0000_0003, 9'h000, 32'h8000_0001, 1'b1}
   };

   int n_checks = 0;
   int n_fail   = 0;
   bit finished = 1'b0;

   task automatic check(input string req, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   function automatic logic top_of(input logic [31:0] d, input logic [1:0] sz);
      case (sz)
         2'd0:    return d[7];
         2'd1:    return d[15];
         default: return d[31];
      endcase
   endfunction

   task automatic drive(input vec_t v);
      in_valid    = 1'b1;
      in_size     = v.size;
      in_src      = v.src;
      in_imm      = v.imm;
      in_creg     = v.creg;
      legacy_mode = v.leg;
      in_data     = v.data;
      in_flags    = v.flags;
   endtask

   initial begin
      #(200000 * 4);
      if (!finished) begin
         n_checks++;
         n_fail++;
         $display("FAIL R9 watchdog: actual hung expected done");
         $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
         $finish;
      end
   end

   initial begin
      logic [8:0]  ef;
      logic [31:0] held;
      rst = 1'b1; in_valid = 1'b0; in_size = '0; in_src = '0; in_imm = '0;
      in_creg = '0; legacy_mode = 1'b0; in_data = '0; in_flags = '0;
      repeat (3) @(negedge clk);
      check("R9", "reset out_valid", 32'(out_valid), 32'd0);
      check("R9", "reset out_data", out_data, 32'd0);
      rst = 1'b0;
      @(negedge clk);
      check("R9", "idle out_valid", 32'(out_valid), 32'd0);

      for (int i = 0; i < NV; i++) begin
         drive(VECS[i]);
         @(negedge clk);
         ef = VECS[i].flags;
         if (VECS[i].exp_we) begin
            ef[0] = VECS[i].exp_data[0];
            ef[8] = top_of(VECS[i].exp_data, VECS[i].size) ^ VECS[i].exp_data[0];
         end
         // R1 R2 R3 R4: rotated data; R5 R6 R7: write-enables and flags; R8 pass
         check("R1/R2/R3/R4", $sformatf("vec %0d data", i), out_data, VECS[i].exp_data);
         check("R5/R6/R7", $sformatf("vec %0d we", i),
               {30'd0, cf_we, of_we}, {30'd0, VECS[i].exp_we, VECS[i].exp_we});
         check("R5/R6/R8", $sformatf("vec %0d flags", i), 32'(out_flags), 32'(ef));
         check("R9", $sformatf("vec %0d out_valid", i), 32'(out_valid), 32'd1);
      end

      // R9: valid drops after strobe removed; outputs hold on new inputs
      held = out_data;
      in_valid = 1'b0; in_data = 32'hDEAD_BEEF; in_src = 2'd1; in_imm = 8'h03;
      @(negedge clk);
      check("R9", "valid drop", 32'(out_valid), 32'd0);
      check("R9", "hold data", out_data, held);

      // R6: sign unchanged gives overflow 0 on count one
      drive('{2'd1, 2'd0, 1'b0, 8'h00, 8'h00, 32'h0000_C000, 9'h100, 32'h0, 1'b1});
      @(negedge clk);
      check("R6", "no sign change data", out_data, 32'h0000_8001);
      check("R6", "no sign change of", 32'(out_flags[8]), 32'd0);

      // R3: masked mode with immediate 0xE0 gives zero count
      drive('{2'd2, 2'd1, 1'b0, 8'hE0, 8'h01, 32'h8765_4321, 9'h0F0, 32'h0, 1'b0});
      @(negedge clk);
      check("R3", "masked E0 data", out_data, 32'h8765_4321);
      check("R3", "masked E0 we", 32'(cf_we), 32'd0);
      legacy_mode = 1'b1;
      @(negedge clk);
      check("R3", "legacy E0 we", 32'(cf_we), 32'd1);
      check("R3", "legacy E0 data", out_data, 32'h8765_4321);

      // R9: synchronous reset clears captured state
      in_valid = 1'b0; rst = 1'b1;
      @(negedge clk);
      check("R9", "reset again valid", 32'(out_valid), 32'd0);
      check("R9", "reset again data", out_data, 32'd0);
      rst = 1'b0;

      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
   end

endmodule